// File: doc/BRIEF.md
# Interrupt Aggregator Group

This block is one group of a source-aggregating interrupt controller. It watches a word of level-sensitive source lines and merges them into a single registered interrupt output. Firmware controls the group through two 32-bit word registers: an enable register and a write-1-to-clear status register. Internally the group keeps a sticky enable set, a mask that firmware raises while its service routine runs, the set of sources currently reported in status, and a pending word for events that arrive while earlier ones are still being serviced.

An event is a cycle in which at least one source line rises. If any of the selected sources is masked or already reported, the whole selected set is deferred into the pending word. Otherwise status is loaded with that set and the output goes high. When firmware clears the last status bit, deferred sources are promoted into status and the output fires again. If nothing is deferred, the output drops.

Top module: `intagg_group`

## Requirements
- R1: An event is evaluated only in a cycle where at least one source line goes from low to high, compared with the previous cycle. The selected set is every line that is high and has its bit in the internal enable set. An event whose selected set is empty changes nothing.
- R2: An event on an idle group replaces status with the selected set and drives `irq_out` high one cycle later. A group is idle when no selected bit is masked and no selected bit is already in status.
- R3: An event on a busy group ORs the whole selected set into the pending word and leaves status and `irq_out` unchanged. A group is busy when some selected bit is masked or already in status.
- R4: Writing zero to the enable register (word offset 0) while the internal enable set is empty stores zero in the enable readback and changes nothing else.
- R5: The internal enable set only grows: a write ORs its data into the set. When that adds bits, the enable readback takes the written value and the mask is left unchanged.
- R6: An enable write that adds no bits works on change = readback XOR data. If (change AND data) is nonzero, the change bits are removed from the mask. Otherwise the change bits are added to the mask. In both cases the readback takes the data.
- R7: The status register (word offset 1) is write-1-to-clear. A status write of zero has no effect.
- R8: A status write of all ones clears status and does nothing else: pending is kept and `irq_out` is unchanged.
- R9: Any other nonzero status write that leaves status at zero does one of two things. If pending is nonzero, it moves pending into status, empties pending and holds `irq_out` high. If pending is zero, it drives `irq_out` low.
- R10: When a register write and an event occur in the same cycle, the write is applied first and the event is judged against the updated enable set, mask and status.
- R11: Reset clears status, enable readback, the enable set, the mask, pending and `irq_out`. Reads return the enable readback at offset 0 and status at offset 1. Other offsets read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lines | input | NUM_SRC | Level source lines |
| bus_valid | input | 1 | Register access valid |
| bus_write | input | 1 | Access is a write |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | NUM_SRC | Write data |
| bus_rdata | output | NUM_SRC | Read data for `bus_addr` (combinational) |
| irq_out | output | 1 | Aggregated interrupt, registered |

## Verification
The bench builds the group with its defaults: NUM_SRC=32 and ADDR_W=2. A 32-bit word makes the all-ones initialisation write a real word-wide pattern. Two address bits leave offsets 2 and 3 unused, so the bench can show that writes to undecoded offsets are dropped. A small group of four low lines is enough to drive the mask and unmask paths, overlap with status, deferral and replay, and a write that lands in the same cycle as an event.

// File: rtl/intagg_pkg.sv
package intagg_pkg;
  // Word offsets of the two decoded registers.
  localparam int unsigned REG_ENABLE_OFS = 0;
  localparam int unsigned REG_STATUS_OFS = 1;

  // How an enable write was interpreted.
  typedef enum logic [2:0] {
    EN_IDLE,
    EN_STORE_ZERO,
    EN_GROW,
    EN_UNMASK,
    EN_MASK
  } en_kind_e;

  // How a status write was interpreted.
  typedef enum logic [2:0] {
    SW_IDLE,
    SW_IGNORED,
    SW_INIT,
    SW_PARTIAL,
    SW_REPLAY,
    SW_QUIET
  } sw_kind_e;
endpackage

// File: rtl/intagg_en_ctrl.sv
module intagg_en_ctrl
  import intagg_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rb_q,
  output logic [W-1:0] set_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] set_nxt,
  output logic [W-1:0] mask_nxt,
  output en_kind_e     kind
);
  logic [W-1:0] rb_nxt;
  logic [W-1:0] change;

  // Decide which of the enable-write behaviours applies.
  function automatic en_kind_e classify(input logic [W-1:0] data,
                                        input logic [W-1:0] set,
                                        input logic [W-1:0] rb);
    if (data == '0 && set == '0) return EN_STORE_ZERO;
    if ((set | data) != set) return EN_GROW;
    if (|((rb ^ data) & data)) return EN_UNMASK;
    return EN_MASK;
  endfunction

  always_comb begin
    kind     = wr_en ? classify(wdata, set_q, rb_q) : EN_IDLE;
    change   = rb_q ^ wdata;
    rb_nxt   = rb_q;
    set_nxt  = set_q;
    mask_nxt = mask_q;
    case (kind)
      EN_STORE_ZERO: rb_nxt = '0;
      EN_GROW: begin
        set_nxt = set_q | wdata;
        rb_nxt  = wdata;
      end
      EN_UNMASK: begin
        mask_nxt = mask_q & ~change;
        rb_nxt   = wdata;
      end
      EN_MASK: begin
        mask_nxt = mask_q | change;
        rb_nxt   = wdata;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rb_q   <= '0;
      set_q  <= '0;
      mask_q <= '0;
    end else begin
      rb_q   <= rb_nxt;
      set_q  <= set_nxt;
      mask_q <= mask_nxt;
    end
  end
endmodule

// File: rtl/intagg_src_sel.sv
module intagg_src_sel #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_lines,
  input  logic [N-1:0] en_set,
  output logic         evt_fire,
  output logic [N-1:0] evt_sel
);
  logic [N-1:0] src_q;
  logic [N-1:0] rise;

  // Per-line rising-edge detect and enable qualification.
  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) src_q[g] <= 1'b0;
      else        src_q[g] <= src_lines[g];
    end
    assign rise[g]    = src_lines[g] & ~src_q[g];
    assign evt_sel[g] = src_lines[g] & en_set[g];
  end

  assign evt_fire = (|rise) & (|evt_sel);
endmodule

// File: rtl/intagg_stat_ctrl.sv
module intagg_stat_ctrl
  import intagg_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         evt_fire,
  input  logic [W-1:0] evt_sel,
  input  logic [W-1:0] mask_nxt,
  output logic [W-1:0] status_q,
  output logic [W-1:0] pending_q,
  output logic         irq_q,
  output sw_kind_e     kind,
  output logic         evt_raised,
  output logic         evt_deferred
);
  logic [W-1:0] st_w, pd_w, st_nxt, pd_nxt;
  logic         irq_w, irq_nxt, busy;

  // Decide which of the status-write behaviours applies.
  function automatic sw_kind_e classify(input logic [W-1:0] data,
                                        input logic [W-1:0] st,
                                        input logic [W-1:0] pd);
    if (data == '0) return SW_IGNORED;
    if (&data) return SW_INIT;
    if ((st & ~data) != '0) return SW_PARTIAL;
    if (pd != '0) return SW_REPLAY;
    return SW_QUIET;
  endfunction

  always_comb begin
    kind  = wr_en ? classify(wdata, status_q, pending_q) : SW_IDLE;
    st_w  = status_q;
    pd_w  = pending_q;
    irq_w = irq_q;
    // Register write first.
    case (kind)
      SW_INIT, SW_PARTIAL: st_w = status_q & ~wdata;
      SW_REPLAY: begin
        st_w  = pending_q;
        pd_w  = '0;
        irq_w = 1'b1;
      end
      SW_QUIET: begin
        st_w  = '0;
        irq_w = 1'b0;
      end
      default: ;
    endcase
    // Then the event, against the updated state.
    busy         = |(evt_sel & (mask_nxt | st_w));
    evt_raised   = evt_fire & ~busy;
    evt_deferred = evt_fire & busy;
    st_nxt  = evt_raised ? evt_sel : st_w;
    irq_nxt = evt_raised ? 1'b1 : irq_w;
    pd_nxt  = evt_deferred ? (pd_w | evt_sel) : pd_w;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q  <= '0;
      pending_q <= '0;
      irq_q     <= 1'b0;
    end else begin
      status_q  <= st_nxt;
      pending_q <= pd_nxt;
      irq_q     <= irq_nxt;
    end
  end
endmodule

// File: rtl/intagg_group.sv
module intagg_group
  import intagg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_lines,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] bus_rdata,
  output logic               irq_out
);
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = ADDR_W'(REG_ENABLE_OFS);
  localparam logic [ADDR_W-1:0] ADDR_STATUS = ADDR_W'(REG_STATUS_OFS);

  logic               wr_enable, wr_status;
  logic [NUM_SRC-1:0] rb_q, set_q, mask_q, set_nxt, mask_nxt;
  logic [NUM_SRC-1:0] status_q, pending_q, evt_sel;
  logic               evt_fire, evt_raised, evt_deferred;
  en_kind_e           en_kind;
  sw_kind_e           sw_kind;

  // Readback selection by word offset.
  function automatic logic [NUM_SRC-1:0] read_mux(input logic [ADDR_W-1:0] a,
                                                  input logic [NUM_SRC-1:0] en_rb,
                                                  input logic [NUM_SRC-1:0] st);
    if (a == ADDR_ENABLE) return en_rb;
    if (a == ADDR_STATUS) return st;
    return '0;
  endfunction

  assign wr_enable = bus_valid & bus_write & (bus_addr == ADDR_ENABLE);
  assign wr_status = bus_valid & bus_write & (bus_addr == ADDR_STATUS);

  intagg_en_ctrl #(.W(NUM_SRC)) en_ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_enable),
    .wdata    (bus_wdata),
    .rb_q     (rb_q),
    .set_q    (set_q),
    .mask_q   (mask_q),
    .set_nxt  (set_nxt),
    .mask_nxt (mask_nxt),
    .kind     (en_kind)
  );

  intagg_src_sel #(.N(NUM_SRC)) src_sel_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_lines (src_lines),
    .en_set    (set_nxt),
    .evt_fire  (evt_fire),
    .evt_sel   (evt_sel)
  );

  intagg_stat_ctrl #(.W(NUM_SRC)) stat_ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_status),
    .wdata        (bus_wdata),
    .evt_fire     (evt_fire),
    .evt_sel      (evt_sel),
    .mask_nxt     (mask_nxt),
    .status_q     (status_q),
    .pending_q    (pending_q),
    .irq_q        (irq_out),
    .kind         (sw_kind),
    .evt_raised   (evt_raised),
    .evt_deferred (evt_deferred)
  );

  assign bus_rdata = read_mux(bus_addr, rb_q, status_q);
endmodule

// File: rtl/intagg_group_chk.sv
module intagg_group_chk
  import intagg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_valid,
  input logic               bus_write,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [NUM_SRC-1:0] bus_wdata,
  input logic               irq_out,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] pending_q,
  input logic [NUM_SRC-1:0] set_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_SRC-1:0] evt_sel,
  input logic               evt_fire,
  input logic               evt_raised,
  input logic               evt_deferred,
  input en_kind_e           en_kind,
  input sw_kind_e           sw_kind
);
  logic st_wr;
  assign st_wr = bus_valid && bus_write && (bus_addr == ADDR_W'(REG_STATUS_OFS));

  // R2
  raise_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_raised |=> irq_out && (status_q == $past(evt_sel)));

  // R3
  defer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_deferred |=> ((pending_q & $past(evt_sel)) == $past(evt_sel)));

  // R5
  sticky_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((set_q & $past(set_q)) == $past(set_q)));

  // R5
  grow_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_kind == EN_GROW) |=> $stable(mask_q));

  // R7
  zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && bus_wdata == '0 && !evt_fire) |=> $stable(status_q) && $stable(irq_out));

  // R8
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && (&bus_wdata) && !evt_fire) |=>
      (status_q == '0) && $stable(irq_out) && $stable(pending_q));

  // R9
  quiet_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_kind == SW_QUIET && !evt_fire) |=> !irq_out);

  // R9
  replay_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_kind == SW_REPLAY && !evt_fire) |=> irq_out && (pending_q == '0) && (status_q != '0));
endmodule

bind intagg_group intagg_group_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_valid    (bus_valid),
  .bus_write    (bus_write),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .irq_out      (irq_out),
  .status_q     (status_q),
  .pending_q    (pending_q),
  .set_q        (set_q),
  .mask_q       (mask_q),
  .evt_sel      (evt_sel),
  .evt_fire     (evt_fire),
  .evt_raised   (evt_raised),
  .evt_deferred (evt_deferred),
  .en_kind      (en_kind),
  .sw_kind      (sw_kind)
);

// File: tb/intagg_group_tb_top.sv
module intagg_group_tb_top;
  localparam int unsigned NSRC = 32;
  localparam int unsigned AW   = 2;
  localparam int unsigned NVEC = 18;

  typedef struct packed {
    logic        wr;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic [31:0] lines;
    logic [31:0] exp_en;
    logic [31:0] exp_st;
    logic        exp_irq;
    logic [3:0]  req;
  } vec_t;

  // wr, addr, wdata, lines, expected enable, expected status, expected irq, requirement
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 2'd0, 32'h0000000F, 32'h0, 32'hF, 32'h0, 1'b0, 4'd5},  // R5 grow
    '{1'b0, 2'd0, 32'h0,        32'h3, 32'hF, 32'h3, 1'b1, 4'd2},  // R2 idle load
    '{1'b0, 2'd0, 32'h0,        32'h7, 32'hF, 32'h3, 1'b1, 4'd3},  // R3 overlaps status
    '{1'b1, 2'd1, 32'h1,        32'h7, 32'hF, 32'h2, 1'b1, 4'd7},  // R7 partial clear
    '{1'b1, 2'd1, 32'h2,        32'h7, 32'hF, 32'h7, 1'b1, 4'd9},  // R9 replay
    '{1'b1, 2'd1, 32'h7,        32'h7, 32'hF, 32'h0, 1'b0, 4'd9},  // R9 drain low
    '{1'b1, 2'd0, 32'h3,        32'h7, 32'h3, 32'h0, 1'b0, 4'd6},  // R6 mask C
    '{1'b0, 2'd0, 32'h0,        32'h0, 32'h3, 32'h0, 1'b0, 4'd1},  // R1 lines fall
    '{1'b0, 2'd0, 32'h0,        32'h4, 32'h3, 32'h0, 1'b0, 4'd3},  // R3 masked
    '{1'b1, 2'd0, 32'hF,        32'h4, 32'hF, 32'h0, 1'b0, 4'd6},  // R6 unmask
    '{1'b1, 2'd1, 32'h1,        32'h4, 32'hF, 32'h4, 1'b1, 4'd9},  // R9 replay from zero status
    '{1'b1, 2'd1, 32'h0,        32'h4, 32'hF, 32'h4, 1'b1, 4'd7},  // R7 zero ignored
    '{1'b1, 2'd1, 32'hFFFFFFFF, 32'h4, 32'hF, 32'h0, 1'b1, 4'd8},  // R8 init keeps irq
    '{1'b1, 2'd1, 32'h1,        32'h4, 32'hF, 32'h0, 1'b0, 4'd9},  // R9 quiet
    '{1'b1, 2'd0, 32'h0,        32'h0, 32'h0, 32'h0, 1'b0, 4'd6},  // R6 zero write masks all
    '{1'b0, 2'd0, 32'h0,        32'h1, 32'h0, 32'h0, 1'b0, 4'd3},  // R3 deferred
    '{1'b1, 2'd1, 32'hFFFFFFFF, 32'h1, 32'h0, 32'h0, 1'b0, 4'd8},  // R8 no replay
    '{1'b1, 2'd1, 32'h1,        32'h1, 32'h0, 32'h1, 1'b1, 4'd9}   // R9 pending survived
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_lines = '0;
  logic            bus_valid = 1'b0;
  logic            bus_write = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [NSRC-1:0] bus_wdata = '0;
  logic [NSRC-1:0] bus_rdata;
  logic            irq_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  intagg_group #(.NUM_SRC(NSRC), .ADDR_W(AW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_lines (src_lines),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  // Called at a falling edge: drive, let one rising edge pass, return at the next falling edge.
  task automatic step(input logic wr, input logic [AW-1:0] a,
                      input logic [31:0] d, input logic [31:0] lines);
    bus_valid = wr;
    bus_write = wr;
    bus_addr  = a;
    bus_wdata = d;
    src_lines = lines;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
    bus_write = 1'b0;
  endtask

  task automatic expect_state(input string tag, input logic [31:0] en,
                              input logic [31:0] st, input logic irq);
    logic [31:0] v;
    rd(AW'(0), v);
    check(tag, "enable", v, en);
    rd(AW'(1), v);
    check(tag, "status", v, st);
    check(tag, "irq", {31'b0, irq_out}, {31'b0, irq});
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    expect_state("R11", 32'h0, 32'h0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i].wr, VEC[i].addr, VEC[i].wdata, VEC[i].lines);
      expect_state($sformatf("R%0d", VEC[i].req), VEC[i].exp_en, VEC[i].exp_st, VEC[i].exp_irq);
    end

    // R11: reset in mid-run returns every register to zero
    rst_n = 1'b0;
    src_lines = '0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    expect_state("R11", 32'h0, 32'h0, 1'b0);

    // R4: zero enable write on an empty set, then an event with nothing enabled
    step(1'b1, AW'(0), 32'h0, 32'h0);
    expect_state("R4", 32'h0, 32'h0, 1'b0);
    step(1'b0, AW'(0), 32'h0, 32'h1);
    expect_state("R4", 32'h0, 32'h0, 1'b0);
    step(1'b0, AW'(0), 32'h0, 32'h0);

    step(1'b1, AW'(0), 32'h1, 32'h0);
    expect_state("R5", 32'h1, 32'h0, 1'b0);
    // R1: a rising line without enable is not selected
    step(1'b0, AW'(0), 32'h0, 32'h2);
    expect_state("R1", 32'h1, 32'h0, 1'b0);
    // R1: only enabled lines enter status
    step(1'b0, AW'(0), 32'h0, 32'h3);
    expect_state("R1", 32'h1, 32'h1, 1'b1);
    step(1'b0, AW'(0), 32'h0, 32'h2);
    // R10: clear and new event in the same cycle
    step(1'b1, AW'(1), 32'h1, 32'h3);
    expect_state("R10", 32'h1, 32'h1, 1'b1);
    // R11: undecoded offset ignores writes and reads zero
    step(1'b1, AW'(2), 32'hFFFF, 32'h3);
    expect_state("R11", 32'h1, 32'h1, 1'b1);
    rd(AW'(2), v);
    check("R11", "unused offset", v, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule